// File: doc/BRIEF.md
# Zero-Suppressing Column Readout Chain

This block moves the stored measurements of one pixel column to the end-of-column receiver as a single serial frame. When readout enable rises, every pixel captures its 8-bit measurement word and its hit flag. The chain then shifts the words towards the end of the column, each pixel passing on what it receives from its neighbour further up. A pixel that saw no hit adds only a single zero flag bit to the frame. A pixel that was hit adds a one flag bit and then its 8-bit word. The upper nibble of the word is the arrival time and the lower nibble is the duration, but the chain does not interpret either field.

Pixels are grouped in pairs, and the frame leaves two bits per readout clock. On the double-data-rate pin the first bit of each pair is driven while the clock is high and the second while it is low. Both bits are also available side by side on a 2-bit bus. A frame-valid output marks the frame. A clock-enable output is high only while the chain is loading or shifting, so the clocks of the pixel array can be gated off at all other times. Dropping readout enable part-way through a frame aborts it.

Top module: `colro_column`

## Requirements
- R1: While reset is asserted and after it is released, `frame_valid`, `pair_out`, `ddr_out` and `pix_clk_en` are all 0 until a frame starts.
- R2: A frame starts only on the clock edge where `rd_en` is sampled 1 after being sampled 0. From the next cycle on, `frame_valid` is 1.
- R3: Each pixel contributes its hit bit first. If the hit bit is 1, data bits 7 down to 0 follow, most significant first. If it is 0, nothing follows.
- R4: Pixel contributions appear in fixed index order, from pixel 0 (next to the end of column) up to pixel DEPTH-1.
- R5: A frame lasts exactly (DEPTH + 8*H)/2 cycles, where H is the number of hit pixels. In frame cycle t, `pair_out[0]` carries frame bit 2t and `pair_out[1]` carries frame bit 2t+1.
- R6: `ddr_out` carries `pair_out[0]` while `clk` is high and `pair_out[1]` while `clk` is low. It is 0 outside a frame.
- R7: `pix_clk_en` is 1 in the load cycle and in every frame cycle, and 0 otherwise.
- R8: If `rd_en` is sampled 0 during a frame, the chain is idle from the next cycle. Holding `rd_en` at 1 after a frame ends does not start another frame.
- R9: Pixel inputs are captured only on the start edge. Changing them during a frame has no effect on that frame.
- R10: A column with no hit pixel produces exactly DEPTH zero bits, which is DEPTH/2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Readout enable; a rising level starts a frame, a low level aborts it |
| pix_hit | input | DEPTH | Hit flag of each pixel, bit 0 next to the end of column |
| pix_data | input | 8*DEPTH | 8-bit word of each pixel, pixel i in bits 8i+7..8i |
| frame_valid | output | 1 | High during every cycle of a frame |
| pair_out | output | 2 | Frame bits 2t (bit 0) and 2t+1 (bit 1) in frame cycle t |
| ddr_out | output | 1 | Double-data-rate serial output |
| pix_clk_en | output | 1 | Clock enable for the pixel array |

## Verification
Several hit patterns drive the frame. An empty column checks the minimum frame length. A full column checks the maximum length and the placement of every data byte. Alternating hits check the interleaving across pixel pairs, since each pair then holds lanes of mixed length. A single hit on the top pixel shows whether data really travels the whole column. Random frames at low, medium and high hit density with random words then check ordering and length together. Further scenarios cover an abort part-way through a frame, an enable held high after a frame ends, and inputs scrambled during a frame; these tell apart a chain that captures its inputs once from one that keeps sampling them.

// File: rtl/colro_pkg.sv
package colro_pkg;

    localparam int PIX_W  = 8;
    localparam int LANE_W = PIX_W + 1;
    localparam int LEN_W  = $clog2(LANE_W + 1);

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } ro_state_e;

    typedef struct packed {
        logic [LANE_W-1:0] even_bits;
        logic [LANE_W-1:0] odd_bits;
        logic [LEN_W-1:0]  len;
    } lane_load_t;

    // Serial contribution of one pixel, bit 0 leaves first.
    function automatic logic [LANE_W-1:0] pix_stream(input logic hit, input logic [PIX_W-1:0] data);
        logic [LANE_W-1:0] s;
        s    = '0;
        s[0] = hit;
        if (hit) begin
            for (int k = 1; k < LANE_W; k++) begin
                s[k] = data[PIX_W-k];
            end
        end
        return s;
    endfunction

    function automatic int unsigned pix_len(input logic hit);
        return hit ? LANE_W : 1;
    endfunction

    // Concatenates two pixel streams and deals them onto an even and an odd lane.
    function automatic lane_load_t pair_split(input logic hit_a, input logic [PIX_W-1:0] data_a,
                                              input logic hit_b, input logic [PIX_W-1:0] data_b);
        logic [2*LANE_W-1:0] s;
        logic [LANE_W-1:0]   sa;
        logic [LANE_W-1:0]   sb;
        int unsigned         la;
        int unsigned         lb;
        lane_load_t          r;
        sa = pix_stream(hit_a, data_a);
        sb = pix_stream(hit_b, data_b);
        la = pix_len(hit_a);
        lb = pix_len(hit_b);
        s  = '0;
        for (int k = 0; k < LANE_W; k++) begin
            if (k < int'(la)) s[k] = sa[k];
        end
        for (int k = 0; k < LANE_W; k++) begin
            if (k < int'(lb)) s[int'(la) + k] = sb[k];
        end
        r = '0;
        for (int j = 0; j < LANE_W; j++) begin
            r.even_bits[j] = s[2*j];
            r.odd_bits[j]  = s[2*j+1];
        end
        r.len = LEN_W'((la + lb) / 2);
        return r;
    endfunction

endpackage

// File: rtl/colro_lane.sv
module colro_lane
    import colro_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [LANE_W-1:0] load_bits,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              din,
    output logic              dout
);

    logic [LANE_W-1:0] q;
    logic [LANE_W-1:0] q_nxt;
    logic [LEN_W-1:0]  len;

    // Variable-length shift register: new bit enters at position len-1.
    always_comb begin
        for (int j = 0; j < LANE_W; j++) begin
            if (j + 1 == int'(len))      q_nxt[j] = din;
            else if (j + 1 < int'(len))  q_nxt[j] = q[j+1];
            else                         q_nxt[j] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            len <= LEN_W'(1);
        end else if (load) begin
            q   <= load_bits;
            len <= load_len;
        end else if (shift) begin
            q   <= q_nxt;
        end
    end

    assign dout = q[0];

    // R3: each lane of a pixel pair holds 1, 5 or 9 bits
    a_r3_lane_len_legal: assert property (@(posedge clk) disable iff (rst)
        (len == LEN_W'(1)) || (len == LEN_W'(5)) || (len == LEN_W'(9)));

    // R9: without load or shift the lane contents do not move
    a_r9_lane_hold: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> $stable(q));

endmodule

// File: rtl/colro_pair_stage.sv
module colro_pair_stage
    import colro_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               shift,
    input  logic [1:0]         hit,
    input  logic [2*PIX_W-1:0] data,
    input  logic [1:0]         in_bits,
    output logic [1:0]         out_bits
);

    lane_load_t ld;

    always_comb begin
        ld = pair_split(hit[0], data[PIX_W-1:0], hit[1], data[2*PIX_W-1:PIX_W]);
    end

    for (genvar ln = 0; ln < 2; ln++) begin : g_lane
        logic [LANE_W-1:0] bits_sel;
        if (ln == 0) begin : g_even
            assign bits_sel = ld.even_bits;
        end else begin : g_odd
            assign bits_sel = ld.odd_bits;
        end
        colro_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .load      (load),
            .shift     (shift),
            .load_bits (bits_sel),
            .load_len  (ld.len),
            .din       (in_bits[ln]),
            .dout      (out_bits[ln])
        );
    end

endmodule

// File: rtl/colro_ctrl.sv
module colro_ctrl
    import colro_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic [DEPTH-1:0] hits,
    output logic             load,
    output logic             shift,
    output logic             frame_valid,
    output logic             clk_en
);

    localparam int MAX_CYC = (DEPTH * LANE_W) / 2;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ro_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] frame_cyc;
    logic             rd_en_q;
    logic             start;

    always_comb begin
        int unsigned nhit;
        nhit = 0;
        for (int i = 0; i < DEPTH; i++) begin
            nhit += {31'd0, hits[i]};
        end
        frame_cyc = CNT_W'(DEPTH / 2 + (nhit * PIX_W) / 2);
    end

    assign start       = (state == ST_IDLE) && rd_en && !rd_en_q;
    assign load        = start;
    assign shift       = (state == ST_SHIFT);
    assign frame_valid = (state == ST_SHIFT);
    assign clk_en      = start || (state == ST_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            rd_en_q <= 1'b0;
        end else begin
            rd_en_q <= rd_en;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_SHIFT;
                        cnt   <= frame_cyc;
                    end
                end
                ST_SHIFT: begin
                    if (!rd_en || cnt == CNT_W'(1)) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: a frame only begins after enable was seen high
    a_r2_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_valid) |-> $past(rd_en));

    // R8: low enable during a frame ends it on the next cycle
    a_r8_abort_stops: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && !rd_en) |=> !frame_valid);

    // R5: remaining cycle count falls by one each frame cycle
    a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && $past(frame_valid) && !$rose(frame_valid)) |-> (cnt == $past(cnt) - CNT_W'(1)));

    // R5: frame ends right after its last cycle
    a_r5_last_cycle: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && cnt == CNT_W'(1)) |=> !frame_valid);

    // R7: pixel clocks run whenever a frame is being shifted
    a_r7_clock_during_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_valid) |-> $past(clk_en));

endmodule

// File: rtl/colro_ddr_out.sv
module colro_ddr_out (
    input  logic       clk,
    input  logic       valid,
    input  logic [1:0] pair_in,
    output logic [1:0] pair_out,
    output logic       ddr_out
);

    assign pair_out = valid ? pair_in : 2'b00;
    assign ddr_out  = clk ? pair_out[0] : pair_out[1];

    // R6: the serial pin stays low outside a frame
    always_comb begin
        if (valid == 1'b0) begin
            a_r6_quiet_idle: assert (ddr_out == 1'b0);
        end
    end

endmodule

// File: rtl/colro_column.sv
module colro_column
    import colro_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic [DEPTH-1:0]   pix_hit,
    input  logic [8*DEPTH-1:0] pix_data,
    output logic               frame_valid,
    output logic [1:0]         pair_out,
    output logic               ddr_out,
    output logic               pix_clk_en
);

    localparam int NPAIR = DEPTH / 2;

    logic       load;
    logic       shift;
    logic [1:0] stage_out [NPAIR];

    colro_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .rd_en       (rd_en),
        .hits        (pix_hit),
        .load        (load),
        .shift       (shift),
        .frame_valid (frame_valid),
        .clk_en      (pix_clk_en)
    );

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        logic [1:0] from_above;
        if (k == NPAIR - 1) begin : g_top
            assign from_above = 2'b00;
        end else begin : g_mid
            assign from_above = stage_out[k+1];
        end
        colro_pair_stage u_stage (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .shift    (shift),
            .hit      (pix_hit[2*k +: 2]),
            .data     (pix_data[2*k*PIX_W +: 2*PIX_W]),
            .in_bits  (from_above),
            .out_bits (stage_out[k])
        );
    end

    colro_ddr_out u_ddr (
        .clk      (clk),
        .valid    (frame_valid),
        .pair_in  (stage_out[0]),
        .pair_out (pair_out),
        .ddr_out  (ddr_out)
    );

    // R1: nothing leaves the column while reset is applied
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!frame_valid && !pix_clk_en));

endmodule

// File: tb/tb_colro_column.sv
module tb_colro_column;

    localparam int DEPTH = 64;
    localparam int MAXB  = DEPTH * 9;

    logic               clk = 1'b0;
    logic               rst;
    logic               rd_en;
    logic [DEPTH-1:0]   pix_hit;
    logic [8*DEPTH-1:0] pix_data;
    logic               frame_valid;
    logic [1:0]         pair_out;
    logic               ddr_out;
    logic               pix_clk_en;

    int  n_cmp  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic exp_bits [MAXB];
    int  exp_n;

    always #5 clk = ~clk;

    colro_column #(.DEPTH(DEPTH)) dut (
        .clk         (clk),
        .rst         (rst),
        .rd_en       (rd_en),
        .pix_hit     (pix_hit),
        .pix_data    (pix_data),
        .frame_valid (frame_valid),
        .pair_out    (pair_out),
        .ddr_out     (ddr_out),
        .pix_clk_en  (pix_clk_en)
    );

    task automatic chk(input string req, input string what, input int act, input int expv);
        n_cmp++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, expv, $time);
        end
    endtask

    // Expected frame per R3/R4: pixel 0 first, hit bit then data MSB first.
    function automatic void build_expected(input logic [DEPTH-1:0] h, input logic [8*DEPTH-1:0] d);
        exp_n = 0;
        for (int i = 0; i < DEPTH; i++) begin
            exp_bits[exp_n] = h[i];
            exp_n++;
            if (h[i]) begin
                for (int k = 7; k >= 0; k--) begin
                    exp_bits[exp_n] = d[i*8 + k];
                    exp_n++;
                end
            end
        end
    endfunction

    task automatic rand_inputs(input int density, output logic [DEPTH-1:0] h, output logic [8*DEPTH-1:0] d);
        for (int i = 0; i < DEPTH; i++) begin
            h[i]         = (($urandom % 100) < density);
            d[i*8 +: 8]  = 8'($urandom);
        end
    endtask

    task automatic run_frame(input logic [DEPTH-1:0] h, input logic [8*DEPTH-1:0] d,
                             input bit scramble, input string tag);
        logic [DEPTH-1:0]   hx;
        logic [8*DEPTH-1:0] dx;
        int bad;
        build_expected(h, d);
        @(negedge clk);
        pix_hit  = h;
        pix_data = d;
        rd_en    = 1'b1;
        #1;
        chk("R7", {tag, " clk_en in load cycle"}, int'(pix_clk_en), 1);
        @(posedge clk);
        if (scramble) begin
            #1;
            rand_inputs(50, hx, dx);
            pix_hit  = ~h;
            pix_data = dx;
        end
        bad = 0;
        for (int t = 0; t < exp_n / 2; t++) begin
            #2;
            if (frame_valid !== 1'b1 || pair_out[0] !== exp_bits[2*t] || ddr_out !== exp_bits[2*t]
                || pix_clk_en !== 1'b1) begin
                bad++;
                $display("FAIL R5 %s cycle %0d high half: actual v=%0b p0=%0b ddr=%0b en=%0b expected v=1 bit=%0b en=1",
                         tag, t, frame_valid, pair_out[0], ddr_out, pix_clk_en, exp_bits[2*t]);
            end
            @(negedge clk);
            #2;
            if (pair_out[1] !== exp_bits[2*t+1] || ddr_out !== exp_bits[2*t+1]) begin
                bad++;
                $display("FAIL R6 %s cycle %0d low half: actual p1=%0b ddr=%0b expected %0b",
                         tag, t, pair_out[1], ddr_out, exp_bits[2*t+1]);
            end
            @(posedge clk);
        end
        n_cmp++;
        if (bad != 0) n_fail++;
        #2;
        chk("R5", {tag, " valid after last cycle"}, int'(frame_valid), 0);
        chk("R7", {tag, " clk_en after frame"}, int'(pix_clk_en), 0);
        // R8: enable still high, no second frame
        repeat (3) @(posedge clk);
        #2;
        chk("R8", {tag, " no restart while enable held"}, int'(frame_valid), 0);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [DEPTH-1:0]   h;
        logic [8*DEPTH-1:0] d;
        void'($urandom(32'h00C0_1DE5));
        rst      = 1'b1;
        rd_en    = 1'b0;
        pix_hit  = '0;
        pix_data = '0;
        repeat (2) @(posedge clk);
        #2;
        chk("R1", "valid in reset", int'(frame_valid), 0);
        chk("R1", "pair in reset", int'(pair_out), 0);
        chk("R1", "clk_en in reset", int'(pix_clk_en), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        chk("R1", "valid after reset", int'(frame_valid), 0);
        chk("R1", "ddr after reset", int'(ddr_out), 0);

        // R2: no start while enable stays low
        repeat (4) @(posedge clk);
        #2;
        chk("R2", "idle without enable", int'(frame_valid), 0);

        // R10: empty column
        h = '0;
        for (int i = 0; i < DEPTH; i++) d[i*8 +: 8] = 8'($urandom);
        run_frame(h, d, 1'b0, "R10 empty");
        chk("R10", "empty frame bit count", exp_n, DEPTH);

        // full column, maximum length
        h = '1;
        run_frame(h, d, 1'b0, "R4 full");

        // alternating hits
        for (int i = 0; i < DEPTH; i++) h[i] = i[0];
        run_frame(h, d, 1'b0, "R3 alternate");

        // only the farthest pixel hit
        h = '0;
        h[DEPTH-1] = 1'b1;
        d[(DEPTH-1)*8 +: 8] = 8'hA5;
        run_frame(h, d, 1'b0, "R4 top only");

        // random densities
        for (int r = 0; r < 6; r++) begin
            rand_inputs((r * 19) % 100, h, d);
            run_frame(h, d, 1'b0, "R5 random");
        end

        // R9: inputs change during frame
        rand_inputs(40, h, d);
        run_frame(h, d, 1'b1, "R9 scrambled");

        // R8: abort part-way
        rand_inputs(60, h, d);
        @(negedge clk);
        pix_hit  = h;
        pix_data = d;
        rd_en    = 1'b1;
        repeat (5) @(posedge clk);
        #2;
        chk("R2", "valid during frame", int'(frame_valid), 1);
        @(negedge clk);
        rd_en = 1'b0;
        @(posedge clk);
        #2;
        chk("R8", "valid after abort", int'(frame_valid), 0);
        chk("R8", "clk_en after abort", int'(pix_clk_en), 0);
        chk("R8", "ddr after abort", int'(ddr_out), 0);
        repeat (3) @(posedge clk);
        #2;
        chk("R8", "stays idle after abort", int'(frame_valid), 0);

        // a fresh frame after the abort is complete
        rand_inputs(30, h, d);
        run_frame(h, d, 1'b0, "R8 after abort");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule